// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

The block is a periodic timer with a 24-bit down-counter and four word registers on a plain request/write register bus: control/status, reload value, current count and a fixed read-only calibration word. While enabled, the counter steps down once per counting cycle. A counting cycle is either every core clock or only the cycles in which an external reference tick is high. After the count reaches zero, the next counting cycle restores the reload value. That zero-to-reload step is the wrap. It sets a sticky status flag and, if enabled, emits a one-cycle interrupt pulse.

Software clears the flag by reading the control/status word. It clears the count by writing any value to the current-count word. A reload value of zero parks the counter at zero. Read data is registered and appears on `rdata_o` in the cycle after the read request. Writes take effect at the clock edge that samples them.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four readable fields are zero except the calibration word: the control/status word, the reload value and the current count. `irq_o` is low.
- R2: Word address 0 is control/status, 1 is reload, 2 is current count and 3 is calibration. Control/status bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the core clock as the count source and bit 16 is the wrap flag. The calibration word always reads `CALIB_VAL`. A read sampled at one edge returns the value held before that edge, on `rdata_o`, in the cycle after that edge.
- R3: When enabled with the core clock selected, a nonzero count drops by one every cycle. A zero count is replaced by the reload value, so wraps repeat every reload+1 cycles.
- R4: Each wrap sets the flag, which then stays set until it is cleared. The first load from zero after reset, after a current-count write or after a zero-reload hold does not set the flag.
- R5: Reading control/status returns the flag and clears it. If a wrap falls on the same edge as the read, the flag stays set.
- R6: Any write to the current-count word forces the count to zero and clears the flag, and it takes priority over counting in that cycle. The next counting cycle loads the reload value without setting the flag.
- R7: While the reload value is zero, counting cycles hold the count at zero, set no flag and raise no interrupt.
- R8: With bit 2 clear, the count changes only in cycles where `ref_tick_i` is high.
- R9: With bit 1 set, each wrap produces exactly one high cycle on `irq_o`, in the cycle after the wrap edge. With bit 1 clear, `irq_o` stays low.
- R10: The reload word stores the low 24 bits of a write, so its maximum is 0xFFFFFF. The upper bits read as zero.
- R11: With bit 0 clear, the count holds its value.
- R12: Writes to the calibration word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ref_tick_i | input | 1 | External reference count enable |
| irq_o | output | 1 | Wrap interrupt pulse |

## Verification
The bench builds the block with its default 24-bit counter and a nonzero calibration constant. It uses small reload values (3, 5 and 10), which keep every wrap within a few dozen cycles. That makes it possible to observe exact reload+1 periods and to place a wrap on the same edge as a status read. It can also follow the flag across a current-count write. A full-scale reload is written only to check that it is stored and masked to 24 bits. Reference-tick counting is checked by counting a known number of tick pulses and confirming that idle core clocks leave the count unchanged.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BIT_RUN    = 0;
  localparam int BIT_IRQ_EN = 1;
  localparam int BIT_CORE   = 2;
  localparam int BIT_WRAP   = 16;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CALIB  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic core_src;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_src.sv
module tick_src (
  input  logic run_i,
  input  logic core_src_i,
  input  logic ref_tick_i,
  output logic step_o
);
  assign step_o = run_i & (core_src_i | ref_tick_i);
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;   // next load from zero is not a wrap
  logic             reload_zero, at_zero;

  assign reload_zero = (reload_i == '0);
  assign at_zero     = (cnt_q == '0);
  assign wrap_o      = step_i & ~clear_i & ~reload_zero & at_zero & ~fresh_q;
  assign count_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (clear_i) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (step_i) begin
      if (reload_zero) begin
        cnt_q   <= '0;
        fresh_q <= 1'b1;
      end else if (at_zero) begin
        cnt_q   <= reload_i;
        fresh_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_q - CNT_W'(1);
      end
    end
  end

  p_decrement_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i && !reload_zero && !at_zero |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_clear_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  p_reload_zero_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clear_i && reload_zero |=> cnt_q == '0);
  p_hold_when_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clear_i |=> $stable(cnt_q));
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CALIB_VAL = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wrap_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             clear_o,
  output logic             irq_o
);
  reg_sel_e         sel;
  logic             wr, rd, rd_ctrl;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q, irq_q;
  logic [31:0]      rdata_q, rd_mux, ctrl_word;

  assign sel     = reg_sel_e'(addr_i);
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign rd_ctrl = rd & (sel == SEL_CTRL);
  assign clear_o = wr & (sel == SEL_COUNT);

  generate
    if (CNT_W < 32) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[31:CNT_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL)
        ctrl_q <= '{core_src: wdata_i[BIT_CORE], irq_en: wdata_i[BIT_IRQ_EN], run: wdata_i[BIT_RUN]};
      if (sel == SEL_RELOAD)
        reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  // clear by count write beats wrap beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (clear_o)  flag_q <= 1'b0;
    else if (wrap_i)   flag_q <= 1'b1;
    else if (rd_ctrl)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap_i & ctrl_q.irq_en;
  end

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[BIT_RUN]    = ctrl_q.run;
    ctrl_word[BIT_IRQ_EN] = ctrl_q.irq_en;
    ctrl_word[BIT_CORE]   = ctrl_q.core_src;
    ctrl_word[BIT_WRAP]   = flag_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rd_mux = ctrl_word;
      SEL_RELOAD: rd_mux = 32'(reload_q);
      SEL_COUNT:  rd_mux = 32'(count_i);
      default:    rd_mux = CALIB_VAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !rd_ctrl && !clear_o |=> flag_q);
  p_flag_rd_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl && !wrap_i |=> !flag_q);
  p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_with_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CALIB_VAL = 32'h0000_2EE0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        ref_tick_i,
  output logic        irq_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             clear, wrap, step;

  tick_regs #(.CNT_W(CNT_W), .CALIB_VAL(CALIB_VAL)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .count_i(count), .wrap_i(wrap), .ctrl_o(ctrl), .reload_o(reload),
    .clear_o(clear), .irq_o
  );

  tick_src u_src (
    .run_i(ctrl.run), .core_src_i(ctrl.core_src), .ref_tick_i, .step_o(step)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .step_i(step), .clear_i(clear), .reload_i(reload),
    .count_o(count), .wrap_o(wrap)
  );

  p_ref_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.core_src && !ref_tick_i && !clear |=> $stable(count));
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam logic [31:0] CALIB = 32'h0000_2EE0;
  localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_COUNT = 2'd2, A_CALIB = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ref_tick = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0, n_fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;
  int          cyc = 0, irq_cnt = 0, last_irq = -1, bad_gap = 0, irq_double = 0;
  logic        irq_prev = 1'b0;
  bit          gap_on = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tick_timer #(.CALIB_VAL(CALIB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ref_tick_i(ref_tick), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: all ops start at a negedge and return at the next one
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    rd_fire <= req & ~we;
    cyc     <= cyc + 1;
  end

  // monitor: reads issued at an edge are compared at the following negedge
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
    if (irq) begin
      irq_cnt++;
      if (gap_on && last_irq >= 0 && (cyc - last_irq) != 4) bad_gap++;
      last_irq = cyc;
    end
    if (irq && irq_prev) irq_double++;
    irq_prev = irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_CTRL,   32'h0, "R1 ctrl reset");
    rd(A_RELOAD, 32'h0, "R1 reload reset");
    rd(A_COUNT,  32'h0, "R1 count reset");
    rd(A_CALIB,  CALIB, "R2 calib value");

    wr(A_RELOAD, 32'hFFFF_FFFF);
    rd(A_RELOAD, 32'h00FF_FFFF, "R10 reload 24-bit max");
    wr(A_CALIB, 32'h1234_5678);
    rd(A_CALIB, CALIB, "R12 calib write ignored");

    // count-down sequence, core clock, no interrupt
    wr(A_RELOAD, 32'd5);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h5);
    rd(A_COUNT, 32'd0, "R2 read returns pre-edge count");
    rd(A_COUNT, 32'd5, "R3 first load from zero");
    rd(A_COUNT, 32'd4, "R3 decrement");
    rd(A_COUNT, 32'd3, "R3 decrement");
    rd(A_CTRL, 32'h5, "R4 no flag on first load");
    rd(A_CTRL, 32'h5, "R4 no flag before wrap");
    rd(A_CTRL, 32'h5, "R5 read on wrap edge returns old flag");
    rd(A_CTRL, 32'h0001_0005, "R5 flag survives same-edge read");
    rd(A_CTRL, 32'h5, "R5 flag cleared by read");
    rd(A_COUNT, 32'd3, "R3 reload after wrap then decrement");
    wr(A_COUNT, 32'h99);
    rd(A_COUNT, 32'd0, "R6 count write zeroes counter");
    rd(A_COUNT, 32'd5, "R6 reload after clear");
    rd(A_CTRL, 32'h5, "R6 no flag on post-clear load");
    idle(4);
    wr(A_COUNT, 32'h0);
    rd(A_CTRL, 32'h5, "R6 count write clears flag");
    rd(A_COUNT, 32'd5, "R6 reload after second clear");
    wr(A_CTRL, 32'h4);
    rd(A_COUNT, 32'd3, "R11 count at stop");
    idle(3);
    rd(A_COUNT, 32'd3, "R11 count held while disabled");

    // interrupt period with reload 3
    wr(A_RELOAD, 32'd3);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h7);
    irq_cnt = 0; last_irq = -1; gap_on = 1'b1;
    idle(20);
    gap_on = 1'b0;
    check("R9 irq pulse count", irq_cnt, 4);
    check("R3 wrap period reload+1", bad_gap, 0);
    rd(A_CTRL, 32'h0001_0007, "R4 flag sticky across wraps");
    wr(A_CTRL, 32'h5);
    irq_cnt = 0;
    idle(12);
    check("R9 no irq when disabled", irq_cnt, 0);

    // zero reload parks the counter
    wr(A_CTRL, 32'h4);
    wr(A_RELOAD, 32'h0);
    wr(A_COUNT, 32'h0);
    rd(A_CTRL, 32'h4, "R6 flag cleared before zero-reload test");
    wr(A_CTRL, 32'h7);
    irq_cnt = 0;
    idle(10);
    rd(A_COUNT, 32'd0, "R7 count parked at zero");
    rd(A_CTRL, 32'h7, "R7 no flag with zero reload");
    check("R7 no irq with zero reload", irq_cnt, 0);

    // external reference ticks
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd10);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h1);
    ticks(5);
    rd(A_COUNT, 32'd6, "R8 count follows reference ticks");
    idle(5);
    rd(A_COUNT, 32'd6, "R8 core cycles ignored without tick");

    idle(2);
    check("R9 irq never two cycles high", irq_double, 0);
    check("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule